// File: doc/BRIEF.md
# Floating-Point Compare and Condition Status Unit

This unit compares two IEEE-754 values, in single or double precision. It records the ordering as a 2-bit condition code inside a 32-bit floating-point status register. A 9-bit operation field selects one of four compare kinds: single, double, and the two trapping forms of each. The trapping forms raise an invalid-operation flag when either operand is a NaN. Any other field value raises an illegal-operation flag.

Operands arrive as 32-bit register words. A single-precision operand is the even word alone. A double-precision operand is an even/odd register pair, with the even word as the high half. The unit also steers the register-file read indices: for a double compare, the low index bit is cleared so that the read lands on the even register of the pair.

The ordering decision is combinational. The status register and both flags are captured on the clock edge that follows a valid strobe.

Top module: `fp_compare_unit`

## Requirements
- R1: After reset, `fpStatus` is zero and `illegalOp` and `invalidTrap` are low.
- R2: Operation field values 0x51 (single), 0x52 (double), 0x55 (single, trapping) and 0x56 (double, trapping) are compares. A valid compare that does not trap writes its condition code into `fpStatus[11:10]` on the next clock edge.
- R3: The condition code is 0 when the operands are equal, 1 when operand A is less than operand B, 2 when A is greater than B, and 3 when they are unordered (at least one is a NaN, non-trapping forms only).
- R4: A compare changes only `fpStatus[11:10]`. Every other status bit keeps its value, which is zero from reset.
- R5: In the trapping forms (0x55, 0x56), a NaN in either operand pulses `invalidTrap` high for the one cycle after the strobe, and `fpStatus` is left unchanged.
- R6: A valid strobe with any other operation field value pulses `illegalOp` high for the one cycle after the strobe, and `fpStatus` is left unchanged.
- R7: In double forms (0x52, 0x56), `readIdxA` and `readIdxB` equal the source index with bit 0 cleared, and the operand is {even word, odd word}. In every other case the read index equals the source index, and a single operand uses only the even word, so the odd words have no effect.
- R8: Positive zero and negative zero compare equal (code 0).
- R9: Ordering is sign-magnitude. When the signs differ, the negative operand is less. When both are negative, the larger magnitude is less. Subnormal values order by magnitude.
- R10: A NaN is a value with an all-ones exponent and a non-zero fraction. Infinities are ordered values: +inf against +inf gives code 0, and -inf is less than any finite value.
- R11: While `opValid` is low, `fpStatus` holds its value and both flags stay low.
- R12: `illegalOp` and `invalidTrap` are never high in the same cycle. Each is high only in the cycle after a valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opField | input | 9 | Operation select field |
| srcIdxA | input | 5 | Register index of operand A |
| srcIdxB | input | 5 | Register index of operand B |
| aEven | input | 32 | Operand A even word (single value, or double high half) |
| aOdd | input | 32 | Operand A odd word (double low half) |
| bEven | input | 32 | Operand B even word |
| bOdd | input | 32 | Operand B odd word |
| readIdxA | output | 5 | Steered register-file read index for A |
| readIdxB | output | 5 | Steered register-file read index for B |
| fpStatus | output | 32 | Floating-point status register |
| illegalOp | output | 1 | Unknown operation pulse |
| invalidTrap | output | 1 | Trap on unordered operands in a trapping form |

## Verification
The only internal state is the status register and the two flag registers. A wrong condition code or a lost bit shows at `fpStatus` one clock after the strobe that caused it, and it stays visible until the next write. A decode fault shows in that same cycle, in one of two ways: a flag pulse that should not be there, or a status write that should have been blocked. The bench therefore checks every cycle against a scoreboard prediction, including idle cycles. It places a strobe next to each corner case (signed zeros, infinities, subnormals, NaNs in the trapping forms, low-word-only differences) so that each fault shows up within one cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    CC_EQUAL     = 2'd0,
    CC_LESS      = 2'd1,
    CC_GREATER   = 2'd2,
    CC_UNORDERED = 2'd3
  } cond_e;

  localparam logic [8:0] OP_CMP_SGL   = 9'h051;
  localparam logic [8:0] OP_CMP_DBL   = 9'h052;
  localparam logic [8:0] OP_CMPX_SGL  = 9'h055;
  localparam logic [8:0] OP_CMPX_DBL  = 9'h056;

  // Strobes from control to datapath
  typedef struct packed {
    logic isDouble;
    logic wrCond;
  } cmpStrobe_t;

endpackage

// File: rtl/fpcmp_core.sv
module fpcmp_core
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] lhs,
  input  logic [EXP_W+FRAC_W:0] rhs,
  output logic                  unordered,
  output cond_e                 relation
);

  localparam int MAG_W = EXP_W + FRAC_W;

  logic              lhsSign, rhsSign;
  logic [MAG_W-1:0]  lhsMag, rhsMag;
  logic              lhsNan, rhsNan;
  logic              bothZero, magLess, magEqual;

  assign lhsSign = lhs[MAG_W];
  assign rhsSign = rhs[MAG_W];
  assign lhsMag  = lhs[MAG_W-1:0];
  assign rhsMag  = rhs[MAG_W-1:0];

  assign lhsNan = (&lhs[MAG_W-1:FRAC_W]) && (|lhs[FRAC_W-1:0]);
  assign rhsNan = (&rhs[MAG_W-1:FRAC_W]) && (|rhs[FRAC_W-1:0]);

  assign unordered = lhsNan || rhsNan;
  assign bothZero  = (lhsMag == '0) && (rhsMag == '0);
  assign magLess   = lhsMag < rhsMag;
  assign magEqual  = lhsMag == rhsMag;

  always_comb begin
    if (unordered) begin
      relation = CC_UNORDERED;
    end else if (bothZero) begin
      relation = CC_EQUAL;
    end else if (lhsSign != rhsSign) begin
      relation = lhsSign ? CC_LESS : CC_GREATER;
    end else if (magEqual) begin
      relation = CC_EQUAL;
    end else if (lhsSign) begin
      relation = magLess ? CC_GREATER : CC_LESS;
    end else begin
      relation = magLess ? CC_LESS : CC_GREATER;
    end
  end

endmodule

// File: rtl/fpcmp_datapath.sv
module fpcmp_datapath
  import fpcmp_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 10,
  parameter int S_EXP    = 8,
  parameter int S_FRAC   = 23,
  parameter int D_EXP    = 11,
  parameter int D_FRAC   = 52
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmpStrobe_t          strobe,
  input  logic [WORD_W-1:0]   aEven,
  input  logic [WORD_W-1:0]   aOdd,
  input  logic [WORD_W-1:0]   bEven,
  input  logic [WORD_W-1:0]   bOdd,
  output logic                unordered,
  output logic [STATUS_W-1:0] status
);

  localparam int S_W = 1 + S_EXP + S_FRAC;
  localparam int D_W = 1 + D_EXP + D_FRAC;

  logic [S_W-1:0] sglA, sglB;
  logic [D_W-1:0] dblA, dblB;
  logic           sglUn, dblUn;
  cond_e          sglRel, dblRel, selRel;

  assign sglA = aEven[S_W-1:0];
  assign sglB = bEven[S_W-1:0];
  assign dblA = {aEven, aOdd};
  assign dblB = {bEven, bOdd};

  fpcmp_core #(.EXP_W(S_EXP), .FRAC_W(S_FRAC)) sglCmp (
    .lhs(sglA), .rhs(sglB), .unordered(sglUn), .relation(sglRel)
  );

  fpcmp_core #(.EXP_W(D_EXP), .FRAC_W(D_FRAC)) dblCmp (
    .lhs(dblA), .rhs(dblB), .unordered(dblUn), .relation(dblRel)
  );

  assign unordered = strobe.isDouble ? dblUn : sglUn;
  assign selRel    = strobe.isDouble ? dblRel : sglRel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
    end else if (strobe.wrCond) begin
      status[CC_LSB +: 2] <= selRel;
    end
  end

endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
#(
  parameter int OP_W  = 9,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opField,
  input  logic [IDX_W-1:0] srcIdxA,
  input  logic [IDX_W-1:0] srcIdxB,
  input  logic             unordered,
  output cmpStrobe_t       strobe,
  output logic [IDX_W-1:0] readIdxA,
  output logic [IDX_W-1:0] readIdxB,
  output logic             illegalOp,
  output logic             invalidTrap
);

  logic isCompare, isDouble, isTrapping, trapNow;

  always_comb begin
    isCompare  = 1'b1;
    isDouble   = 1'b0;
    isTrapping = 1'b0;
    case (opField)
      OP_CMP_SGL:  ;
      OP_CMP_DBL:  isDouble = 1'b1;
      OP_CMPX_SGL: isTrapping = 1'b1;
      OP_CMPX_DBL: begin isDouble = 1'b1; isTrapping = 1'b1; end
      default:     isCompare = 1'b0;
    endcase
  end

  assign trapNow         = opValid && isCompare && isTrapping && unordered;
  assign strobe.isDouble = isDouble;
  assign strobe.wrCond   = opValid && isCompare && !trapNow;

  assign readIdxA = isDouble ? {srcIdxA[IDX_W-1:1], 1'b0} : srcIdxA;
  assign readIdxB = isDouble ? {srcIdxB[IDX_W-1:1], 1'b0} : srcIdxB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegalOp   <= 1'b0;
      invalidTrap <= 1'b0;
    end else begin
      illegalOp   <= opValid && !isCompare;
      invalidTrap <= trapNow;
    end
  end

endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
  import fpcmp_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 10,
  parameter int OP_W     = 9,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic [OP_W-1:0]     opField,
  input  logic [IDX_W-1:0]    srcIdxA,
  input  logic [IDX_W-1:0]    srcIdxB,
  input  logic [WORD_W-1:0]   aEven,
  input  logic [WORD_W-1:0]   aOdd,
  input  logic [WORD_W-1:0]   bEven,
  input  logic [WORD_W-1:0]   bOdd,
  output logic [IDX_W-1:0]    readIdxA,
  output logic [IDX_W-1:0]    readIdxB,
  output logic [STATUS_W-1:0] fpStatus,
  output logic                illegalOp,
  output logic                invalidTrap
);

  cmpStrobe_t strobe;
  logic       unordered;

  fpcmp_ctrl #(.OP_W(OP_W), .IDX_W(IDX_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opField(opField),
    .srcIdxA(srcIdxA), .srcIdxB(srcIdxB), .unordered(unordered),
    .strobe(strobe), .readIdxA(readIdxA), .readIdxB(readIdxB),
    .illegalOp(illegalOp), .invalidTrap(invalidTrap)
  );

  fpcmp_datapath #(.WORD_W(WORD_W), .STATUS_W(STATUS_W), .CC_LSB(CC_LSB)) dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .aEven(aEven), .aOdd(aOdd), .bEven(bEven), .bOdd(bOdd),
    .unordered(unordered), .status(fpStatus)
  );

endmodule

// File: rtl/fp_compare_unit_chk.sv
module fp_compare_unit_chk #(
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 10,
  parameter int OP_W     = 9,
  parameter int IDX_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                opValid,
  input logic [OP_W-1:0]     opField,
  input logic [IDX_W-1:0]    readIdxA,
  input logic [STATUS_W-1:0] fpStatus,
  input logic                illegalOp,
  input logic                invalidTrap
);

  logic [STATUS_W-1:0] otherMask;
  assign otherMask = ~({{(STATUS_W-2){1'b0}}, 2'b11} << CC_LSB);

  // R5
  trap_holds_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidTrap |-> fpStatus == $past(fpStatus));

  // R6
  illegal_holds_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> fpStatus == $past(fpStatus));

  // R11
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> $stable(fpStatus) && !illegalOp && !invalidTrap);

  // R12
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({illegalOp, invalidTrap}) <= 1);

  // R4
  other_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fpStatus & otherMask) == '0);

  // R7
  pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opField == 9'h052 || opField == 9'h056) |-> readIdxA[0] == 1'b0);

endmodule

bind fp_compare_unit fp_compare_unit_chk #(
  .STATUS_W(STATUS_W), .CC_LSB(CC_LSB), .OP_W(OP_W), .IDX_W(IDX_W)
) chk (
  .clk(clk), .rst_n(rst_n), .opValid(opValid), .opField(opField),
  .readIdxA(readIdxA), .fpStatus(fpStatus),
  .illegalOp(illegalOp), .invalidTrap(invalidTrap)
);

// File: tb/fp_compare_unit_test.sv
module fp_compare_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [8:0]  opField = 9'h051;
  logic [4:0]  srcIdxA = '0, srcIdxB = '0;
  logic [31:0] aEven = '0, aOdd = '0, bEven = '0, bOdd = '0;
  logic [4:0]  readIdxA, readIdxB;
  logic [31:0] fpStatus;
  logic        illegalOp, invalidTrap;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] expFsr = '0;
  logic [33:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  fp_compare_unit uut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opField(opField),
    .srcIdxA(srcIdxA), .srcIdxB(srcIdxB),
    .aEven(aEven), .aOdd(aOdd), .bEven(bEven), .bOdd(bOdd),
    .readIdxA(readIdxA), .readIdxB(readIdxB), .fpStatus(fpStatus),
    .illegalOp(illegalOp), .invalidTrap(invalidTrap)
  );

  function automatic bit sglNan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit dblNan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic real sglReal(logic [31:0] v);
    real mag;
    int  e;
    e = int'(v[30:23]);
    if (e == 255)    mag = 1.0e300;
    else if (e == 0) mag = real'(v[22:0]) * (2.0 ** (-149));
    else             mag = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return v[31] ? -mag : mag;
  endfunction

  function automatic logic [1:0] order(real x, real y, bit nan);
    if (nan)        return 2'd3;
    else if (x == y) return 2'd0;
    else if (x < y)  return 2'd1;
    else             return 2'd2;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: one strobe per call, expected result pushed to scoreboard
  task automatic doOp(logic [8:0] op, logic [4:0] ia, logic [4:0] ib,
                      logic [31:0] ae, logic [31:0] ao,
                      logic [31:0] be, logic [31:0] bo, string tag);
    bit dbl, trapping, legal, nan;
    logic [1:0] cc;
    logic ill, trp;
    @(negedge clk);
    opValid = 1'b1; opField = op; srcIdxA = ia; srcIdxB = ib;
    aEven = ae; aOdd = ao; bEven = be; bOdd = bo;
    legal    = (op == 9'h051) || (op == 9'h052) || (op == 9'h055) || (op == 9'h056);
    dbl      = (op == 9'h052) || (op == 9'h056);
    trapping = (op == 9'h055) || (op == 9'h056);
    if (dbl) begin
      nan = dblNan({ae, ao}) || dblNan({be, bo});
      cc  = order($bitstoreal({ae, ao}), $bitstoreal({be, bo}), nan);
    end else begin
      nan = sglNan(ae) || sglNan(be);
      cc  = order(sglReal(ae), sglReal(be), nan);
    end
    ill = !legal;
    trp = legal && trapping && nan;
    if (legal && !trp) expFsr[11:10] = cc;
    expQ.push_back({expFsr, ill, trp});
    tagQ.push_back(tag);
    #1;
    check({tag, " R7 index"}, {54'd0, readIdxA, readIdxB},
          {54'd0, dbl ? {ia[4:1], 1'b0} : ia, dbl ? {ib[4:1], 1'b0} : ib});
  endtask

  task automatic doIdle(logic [8:0] op, logic [31:0] ae, logic [31:0] be);
    @(negedge clk);
    opValid = 1'b0; opField = op; aEven = ae; bEven = be;
    expQ.push_back({expFsr, 1'b0, 1'b0});
    tagQ.push_back("R11 idle");
  endtask

  // Monitor: compare results away from the clock edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [33:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {30'd0, fpStatus, illegalOp, invalidTrap}, {30'd0, e});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {31'd0, fpStatus, illegalOp, invalidTrap}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'd0, fpStatus, illegalOp, invalidTrap}, 64'd0);

    // R2/R3 single: 2.0 vs 1.0 greater, 1.0 vs 2.0 less, equal
    doOp(9'h051, 5'd3, 5'd4, 32'h40000000, 0, 32'h3F800000, 0, "R2 R3 single greater");
    doOp(9'h051, 5'd3, 5'd4, 32'h3F800000, 0, 32'h40000000, 0, "R3 single less");
    doOp(9'h051, 5'd3, 5'd4, 32'h3F800000, 32'h1234, 32'h3F800000, 32'h9999, "R7 single ignores odd");
    // R3 unordered in non-trapping single
    doOp(9'h051, 5'd1, 5'd2, 32'h7FC00000, 0, 32'h3F800000, 0, "R3 R10 single unordered");
    // R8 signed zeros
    doOp(9'h051, 5'd1, 5'd2, 32'h80000000, 0, 32'h00000000, 0, "R8 zeros single");
    doOp(9'h052, 5'd5, 5'd7, 32'h80000000, 0, 32'h00000000, 0, "R8 zeros double");
    // R9 sign-magnitude
    doOp(9'h051, 5'd1, 5'd2, 32'hBF800000, 0, 32'h3F800000, 0, "R9 neg vs pos");
    doOp(9'h051, 5'd1, 5'd2, 32'hC0000000, 0, 32'hBF800000, 0, "R9 both neg larger mag less");
    doOp(9'h051, 5'd1, 5'd2, 32'h00000001, 0, 32'h00000002, 0, "R9 subnormal");
    doOp(9'h051, 5'd1, 5'd2, 32'h80000001, 0, 32'h00000000, 0, "R9 neg subnormal vs zero");
    // R10 infinities and NaN definition
    doOp(9'h051, 5'd1, 5'd2, 32'h7F800000, 0, 32'h7F800000, 0, "R10 inf equal");
    doOp(9'h051, 5'd1, 5'd2, 32'hFF800000, 0, 32'hC0000000, 0, "R10 -inf less");
    doOp(9'h055, 5'd1, 5'd2, 32'h7F800000, 0, 32'h3F800000, 0, "R10 inf no trap");
    // R2 double, difference only in low word
    doOp(9'h052, 5'd9, 5'd11, 32'h3FF00000, 32'h00000001, 32'h3FF00000, 0, "R2 R7 double low word");
    doOp(9'h052, 5'd9, 5'd11, 32'hC0000000, 0, 32'hBFF00000, 0, "R9 double both neg");
    doOp(9'h052, 5'd9, 5'd11, 32'h7FF00000, 32'h1, 32'h0, 0, "R3 R10 double nan low frac");
    // R5 trapping forms
    doOp(9'h051, 5'd0, 5'd0, 32'h40000000, 0, 32'h3F800000, 0, "R5 setup");
    doOp(9'h055, 5'd0, 5'd0, 32'h3F800000, 0, 32'h7FC00000, 0, "R5 single trap");
    doOp(9'h056, 5'd2, 5'd3, 32'h7FF80000, 0, 32'h0, 0, "R5 double trap");
    doOp(9'h056, 5'd2, 5'd3, 32'h3FF00000, 0, 32'h40000000, 0, "R2 double trapping ordered");
    doOp(9'h055, 5'd2, 5'd3, 32'h3F800000, 0, 32'h3F800000, 0, "R2 single trapping equal");
    // R6 illegal codes
    doOp(9'h053, 5'd2, 5'd3, 32'h7FC00000, 0, 32'h0, 0, "R6 illegal 0x53");
    doOp(9'h000, 5'd2, 5'd3, 32'h40000000, 0, 32'h3F800000, 0, "R6 illegal 0x00");
    doOp(9'h151, 5'd2, 5'd3, 32'h40000000, 0, 32'h3F800000, 0, "R6 illegal 0x151");
    // R11 idle cycles with compare-looking stimulus
    doIdle(9'h051, 32'h40000000, 32'h3F800000);
    doIdle(9'h053, 32'h7FC00000, 32'h0);
    // R12 flags drop after one cycle, R4 other bits
    doOp(9'h051, 5'd1, 5'd2, 32'h3F800000, 0, 32'h40000000, 0, "R12 R4 after flags");
    doIdle(9'h055, 32'h7FC00000, 32'h7FC00000);

    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule